// File: doc/BRIEF.md
# Hypercube Tree Reduction Summer

This block adds up a vector of unsigned words. The adders are organised as a binary hypercube of `NODES = 2^DIMS` processing elements. A single-cycle start pulse copies every input word into that node's running-sum register. The controller then walks the cube dimensions from the highest down to the lowest, one dimension per clock. In the step for dimension `j`, every node whose index is below `2^j` pulls the sum held by its neighbour across that dimension, at index `+2^j`, and adds it to its own sum. Every other node keeps its value. The set of working nodes therefore halves at each step. After `DIMS` steps node 0 holds the grand total.

The result port always shows node 0's register. A one-cycle done pulse marks the cycle in which that register first holds the finished total. The sum registers are `IN_W + DIMS` bits wide, so the total of all-maximum inputs still fits. The block runs one reduction at a time. A start pulse that arrives while a reduction is in flight has no effect.

Top module: `hcube_reduce`

## Requirements
- R1: A start pulse sampled while the block is idle captures all `NODES` input words at that clock edge. The input vector may change on any later cycle without affecting the result.
- R2: After the capture edge the block performs exactly `DIMS` steps on consecutive clock edges, visiting dimensions `DIMS-1, DIMS-2, ..., 0` in that order.
- R3: In the step for dimension `j`, each node `i < 2^j` adds the value held by node `i + 2^j` before that edge to its own sum. Input word `i` is bits `[i*IN_W +: IN_W]` of `in_vec`.
- R4: In any step, a node that is not receiving keeps its sum unchanged. Each input therefore enters the total exactly once. For example, inputs with value `2^i` on node `i` give a total of `2^NODES - 1`.
- R5: Sums are `IN_W + DIMS` bits wide and never wrap. With every input at `2^IN_W - 1` the result is `NODES * (2^IN_W - 1)`.
- R6: `done` is high for exactly one cycle. That cycle follows the clock edge `DIMS` edges after the capture edge.
- R7: While `done` is high, `result` equals the unsigned sum of the captured inputs. It keeps that value until the next accepted start.
- R8: A start pulse that arrives while a reduction is running is ignored. There is no reload, no extra `done`, and no change to the timing or value of the running reduction.
- R9: After reset, `done` is low and `result` is zero.
- R10: A start pulse sampled in the cycle where `done` is high is accepted and begins a new reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction; sampled at the rising edge |
| in_vec | input | NODES*IN_W | Packed input words; word i at bits [i*IN_W +: IN_W] |
| result | output | IN_W+log2(NODES) | Node 0 running sum; the total when done is high |
| done | output | 1 | One-cycle pulse when result holds the finished total |

## Verification
Inputs with value `2^i` on node `i` expose any node that is added twice or skipped. Such a fault would show up as a wrong bit pattern in the total rather than a plausible-looking number. All-maximum inputs target the sum width: a design that truncated its sums would wrap and return a small value. The bench changes the input vector right after the capture edge, which catches a design that keeps sampling its inputs. It also fires a second start in the middle of a run, which catches a design that restarts, or that emits an extra or a late `done`. Back-to-back runs launched in the `done` cycle catch a controller that needs an extra idle cycle, and the scoreboard's cycle stamps catch a `done` pulse that arrives early or late.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   function automatic int cube_dims(input int n);
      return $clog2(n);
   endfunction

   function automatic int index_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hcr_step_ctrl.sv
module hcr_step_ctrl #(
   parameter int DIMS   = 3,
   parameter int STEP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              load,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              done
);
   localparam int LAT_W = $clog2(DIMS + 1) + 1;

   logic [LAT_W-1:0] lat_q;

   assign load = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         step  <= '0;
         done  <= 1'b0;
         lat_q <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy  <= 1'b1;
            step  <= STEP_W'(DIMS - 1);
            lat_q <= '0;
         end else if (busy) begin
            lat_q <= lat_q + 1'b1;
            if (step == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step <= step - 1'b1;
            end
         end
      end
   end

   // R2: dimensions are visited in descending order, one per clock
   assert_step_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step != '0) |=> (busy && step == $past(step) - 1'b1));

   // R8: a start during a run neither aborts nor restarts it
   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && step != '0) |=> (busy && step == $past(step) - 1'b1));

   // R6: done is a single-cycle pulse
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: done arrives exactly DIMS edges after capture
   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LAT_W'(DIMS)));

endmodule

// File: rtl/hcr_acc_node.sv
module hcr_acc_node #(
   parameter int IN_W  = 8,
   parameter int SUM_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             acc,
   input  logic [IN_W-1:0]  din,
   input  logic [SUM_W-1:0] partner,
   output logic [SUM_W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (load) begin
         sum <= SUM_W'(din);
      end else if (acc) begin
         sum <= sum + partner;
      end
   end

   // R5: accumulation never wraps
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (sum >= $past(sum)));

   // R8: capture and accumulation never coincide
   assert_no_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && acc));

endmodule

// File: rtl/hcr_hold_node.sv
module hcr_hold_node #(
   parameter int IN_W  = 8,
   parameter int SUM_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             busy,
   input  logic [IN_W-1:0]  din,
   output logic [SUM_W-1:0] sum
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum <= '0;
      end else if (load) begin
         sum <= SUM_W'(din);
      end
   end

   // R4: an upper-half node never changes during a run
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(sum));

endmodule

// File: rtl/hcube_reduce.sv
module hcube_reduce
   import hcr_pkg::*;
#(
   parameter int NODES = 8,
   parameter int IN_W  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [NODES*IN_W-1:0]           in_vec,
   output logic [IN_W+$clog2(NODES)-1:0]   result,
   output logic                            done
);
   localparam int DIMS   = cube_dims(NODES);
   localparam int SUM_W  = IN_W + DIMS;
   localparam int STEP_W = index_bits(DIMS);
   localparam int HALF   = NODES / 2;

   if (!is_pow2(NODES)) begin : g_bad_nodes
      $fatal(1, "NODES must be a power of two of at least 2");
   end
   if (IN_W < 1) begin : g_bad_width
      $fatal(1, "IN_W must be at least 1");
   end

   logic              load;
   logic              busy;
   logic [STEP_W-1:0] step;
   logic [SUM_W-1:0]  sums [NODES];

   hcr_step_ctrl #(.DIMS(DIMS), .STEP_W(STEP_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .busy  (busy),
      .step  (step),
      .done  (done)
   );

   for (genvar n = 0; n < NODES; n++) begin : g_node
      if (n < HALF) begin : g_acc
         logic [SUM_W-1:0] cand [DIMS];
         logic [SUM_W-1:0] partner;
         logic             acc_en;

         for (genvar d = 0; d < DIMS; d++) begin : g_dim
            if (n < (1 << d)) begin : g_link
               assign cand[d] = sums[n + (1 << d)];
            end else begin : g_nolink
               assign cand[d] = '0;
            end
         end

         assign partner = cand[step];
         assign acc_en  = busy && (n < (32'd1 << step));

         hcr_acc_node #(.IN_W(IN_W), .SUM_W(SUM_W)) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .acc     (acc_en),
            .din     (in_vec[n*IN_W +: IN_W]),
            .partner (partner),
            .sum     (sums[n])
         );
      end else begin : g_hold
         hcr_hold_node #(.IN_W(IN_W), .SUM_W(SUM_W)) u_node (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .busy  (busy),
            .din   (in_vec[n*IN_W +: IN_W]),
            .sum   (sums[n])
         );
      end
   end

   assign result = sums[0];

   // R7: the total is held from done until the next accepted start
   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !load) |=> $stable(result));

endmodule

// File: tb/hcube_reduce_bench.sv
module hcube_reduce_bench;
   localparam int NODES = 8;
   localparam int IN_W  = 8;
   localparam int DIMS  = $clog2(NODES);
   localparam int SUM_W = IN_W + DIMS;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  start = 1'b0;
   logic [NODES*IN_W-1:0] in_vec = '0;
   logic [SUM_W-1:0]      result;
   logic                  done;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit finished = 1'b0;
   bit prev_done = 1'b0;
   logic [SUM_W-1:0] last_total = '0;

   logic [SUM_W-1:0] q_total [$];
   int               q_due   [$];

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   hcube_reduce #(.NODES(NODES), .IN_W(IN_W)) u_hcube_reduce (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .in_vec (in_vec),
      .result (result),
      .done   (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [SUM_W-1:0] ref_sum(input logic [NODES*IN_W-1:0] v);
      logic [SUM_W-1:0] s = '0;
      for (int i = 0; i < NODES; i++) s += SUM_W'(v[i*IN_W +: IN_W]);
      return s;
   endfunction

   // Driver: called at a negedge; pulses start for one cycle.
   task automatic launch(input logic [NODES*IN_W-1:0] v, input bit garble);
      in_vec = v;
      start  = 1'b1;
      q_total.push_back(ref_sum(v));
      q_due.push_back(cyc + 1 + DIMS);
      @(negedge clk);
      start = 1'b0;
      if (garble) in_vec = ~v;   // R1: late input changes must not matter
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done) begin
            check(!prev_done, "R6", "done wider than one cycle", 1, 0);
            if (q_total.size() == 0) begin
               check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
               check(result == q_total[0], "R7", "total at done", result, q_total[0]);
               check(cyc == q_due[0], "R6", "done cycle", cyc, q_due[0]);
               last_total = q_total[0];
               void'(q_total.pop_front());
               void'(q_due.pop_front());
            end
         end else if (q_due.size() != 0 && cyc > q_due[0]) begin
            check(1'b0, "R6", "done missing at cycle", cyc, q_due[0]);
            void'(q_total.pop_front());
            void'(q_due.pop_front());
         end
         prev_done = done;
      end
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [NODES*IN_W-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(done == 1'b0, "R9", "done after reset", done, 0);
      check(result == '0, "R9", "result after reset", result, 0);

      // R3 / R4: one-hot weights expose skipped or doubled nodes
      for (int i = 0; i < NODES; i++) v[i*IN_W +: IN_W] = IN_W'(1 << i);
      launch(v, 1'b0);
      wait_done();

      // R5: all-maximum inputs must not wrap
      @(negedge clk);
      launch('1, 1'b0);
      wait_done();
      check(result == SUM_W'(NODES * ((1 << IN_W) - 1)), "R5", "all-max total",
            result, NODES * ((1 << IN_W) - 1));

      // R7: result held after done
      repeat (3) @(negedge clk);
      check(result == last_total, "R7", "result hold", result, last_total);

      // R1: inputs changed right after capture are ignored
      @(negedge clk);
      for (int i = 0; i < NODES; i++) v[i*IN_W +: IN_W] = IN_W'(i + 1);
      launch(v, 1'b1);
      wait_done();

      // R8: start during a run is ignored
      @(negedge clk);
      for (int i = 0; i < NODES; i++) v[i*IN_W +: IN_W] = IN_W'(10 * i + 3);
      launch(v, 1'b0);
      in_vec = '1;
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (DIMS + 4) @(negedge clk);
      check(q_total.size() == 0, "R8", "pending runs after ignored start",
            q_total.size(), 0);
      check(result == last_total, "R8", "result after ignored start", result, last_total);

      // R2 / R10: back-to-back random runs launched in the done cycle
      @(negedge clk);
      for (int r = 0; r < 20; r++) begin
         for (int i = 0; i < NODES; i++) v[i*IN_W +: IN_W] = IN_W'($urandom);
         launch(v, r[0]);
         wait_done();
      end
      repeat (DIMS + 4) @(negedge clk);
      check(q_total.size() == 0, "R10", "all back-to-back runs completed",
            q_total.size(), 0);
      finish_run();
   end

endmodule